// File: doc/BRIEF.md
# TLB Duplicate-Entry Scrubber

This block is a recovery sequencer for a set-associative translation buffer. After one start pulse it walks every set in ascending order and reads the tag descriptor of each way through a one-cycle-latency read port. It keeps a masked local copy of each page tag and then looks for ways in the same set that carry identical page tags. For each duplicate pair it removes the lower-numbered way by pulsing an erase strobe at that way's linear index, and it keeps the higher-numbered way. When it has finished the last set it raises a single-cycle done pulse.

Each erase is reported on a side channel that carries the set, the two way numbers and the page tag, in the same cycle as the erase strobe. A silence input turns this report off without changing which entries are removed. The logic that decides when to run the scrubber, and the tag storage itself, are outside the block. At most four ways per set are scanned. The `WAYS` parameter still sets the stride of the linear index.

Top module: `tlb_dup_scrubber`

## Requirements
- R1: While reset is held, `done`, `tlb_rd`, `tlb_erase` and `rpt_valid` are all low.
- R2: A run reads every entry exactly once, in ascending set order and ascending way order within a set, at linear index set*WAYS+way. A read strobe is never high in two consecutive cycles. Read data are taken in the cycle after the strobe.
- R3: Bit `VLD_POS` of a descriptor is its present flag. Only bits [TAG_W-1:FLAG_W] (the page part) take part in a comparison, so two entries whose flags differ but whose pages are equal are duplicates.
- R4: If no way of a set has its present flag set, the set gets no comparison and no erase, even when its pages are equal.
- R5: Pairs are examined with the outer way running from 0 upwards and the inner way from outer+1 to the last way. An outer way whose page part is zero is skipped. Once the set has at least one present way, an inner way takes part whether or not its own present flag is set.
- R6: On a match the outer (lower) way is erased with a one-cycle `tlb_erase` at its index, and the higher way is kept. The erased way then leaves the comparison, so a way is erased at most once per run. When all ways of a set carry the same page, every way except the last is erased.
- R7: When not silenced, each erase comes with `rpt_valid` in the same cycle. The report carries the set, the lower and upper way numbers (lower < upper) and the page-masked tag, in the order in which the erases happen.
- R8: While `silent` is high, `rpt_valid` stays low, but the same entries are erased.
- R9: After the last set `done` is high for exactly one cycle. A `start` pulse received during a run is ignored and causes neither a second pass nor a second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a scrub pass |
| silent | input | 1 | Suppresses duplicate reports |
| done | output | 1 | One-cycle pulse at the end of a pass |
| tlb_idx | output | IDX_W | Linear entry index for read or erase |
| tlb_rd | output | 1 | Read strobe; data valid on the next cycle |
| tlb_rdata | input | TAG_W | Tag descriptor read from storage |
| tlb_erase | output | 1 | Write an all-zero descriptor at `tlb_idx` |
| rpt_valid | output | 1 | Duplicate report valid |
| rpt_set | output | SET_W | Set of the reported duplicate |
| rpt_way_lo | output | WAY_W | Erased (lower) way |
| rpt_way_hi | output | WAY_W | Kept (higher) way |
| rpt_tag | output | TAG_W | Page-masked tag of the duplicate |

## Verification
The hardest situation to reach is a chain of duplicates within one set, where the outcome depends on the outer way leaving the comparison after its erase. It sits next to the quieter cases: a set with equal pages but no present way, a zero page that must be skipped, and an inner way that matches while its present flag is clear. Directed descriptor patterns place each of these in its own set of one pass. Random passes draw pages from a pool of only four values, so that multi-way collisions appear often. A bench reference walk predicts the final storage and the report sequence for every pass.

// File: rtl/scrub_pkg.sv
// Shared definitions for the duplicate-entry scrubber.
// Assumes nothing beyond IEEE 1800-2017 packages.
package scrub_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD   = 3'd1,
        S_WT   = 3'd2,
        S_CHK  = 3'd3,
        S_CMP  = 3'd4,
        S_NX   = 3'd5,
        S_DN   = 3'd6
    } scrub_state_t;

endpackage

// File: rtl/scrub_tag_bank.sv
// Local copy of the page tags of the set under examination.
// Each way holds its page-masked tag. A present-flag accumulator records
// whether any way of the set is present. Assumes that capture and kill
// never target the same way in one cycle.
module scrub_tag_bank #(
    parameter int NW      = 4,
    parameter int TAG_W   = 20,
    parameter int FLAG_W  = 8,
    parameter int VLD_POS = 3,
    parameter int WAY_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_any,
    input  logic                      cap,
    input  logic [WAY_W-1:0]          cap_way,
    input  logic [TAG_W-1:0]          cap_data,
    input  logic                      kill,
    input  logic [WAY_W-1:0]          kill_way,
    output logic [NW-1:0][TAG_W-1:0]  tags,
    output logic                      any_valid
);

    localparam logic [TAG_W-1:0] PMASK = {{(TAG_W-FLAG_W){1'b1}}, {FLAG_W{1'b0}}};

    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_way
            // Hold one way's page tag: load on capture, zero on kill.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tags[g] <= '0;
                else if (cap && cap_way == WAY_W'(g))
                    tags[g] <= cap_data & PMASK;
                else if (kill && kill_way == WAY_W'(g))
                    tags[g] <= '0;
            end
        end
    endgenerate

    // Accumulate the present flags of the ways captured for this set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_any)
            any_valid <= 1'b0;
        else if (cap && cap_data[VLD_POS])
            any_valid <= 1'b1;
    end

endmodule

// File: rtl/scrub_pair_seq.sv
// Outer/inner way pair counter for the pairwise comparison of one set.
// init loads (0,1); step_outer moves to (o+1, o+2); step_inner moves to
// (o, i+1). Assumes NW >= 2 and that the caller never steps past the
// last pair.
module scrub_pair_seq #(
    parameter int NW    = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step_outer,
    input  logic             step_inner,
    output logic [WAY_W-1:0] outer,
    output logic [WAY_W-1:0] inner,
    output logic             outer_last,
    output logic             inner_last
);

    // Advance the pair position under control of the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            outer <= '0;
            inner <= WAY_W'(1);
        end else if (step_outer) begin
            outer <= outer + WAY_W'(1);
            inner <= outer + WAY_W'(2);
        end else if (step_inner) begin
            inner <= inner + WAY_W'(1);
        end
    end

    // Flag the final positions of the two loops.
    always_comb begin
        outer_last = (outer == WAY_W'(NW - 2));
        inner_last = (inner == WAY_W'(NW - 1));
    end

endmodule

// File: rtl/tlb_dup_scrubber.sv
// Top of the duplicate-entry scrubber. It walks all sets, reads up to four
// ways per set over a one-cycle-latency read port and compares the page
// tags pairwise. For each duplicate it erases the lower way and reports it.
// Assumes WAYS >= 2 and that the storage performs an erase at tlb_idx in
// the cycle in which tlb_erase is high.
module tlb_dup_scrubber
    import scrub_pkg::*;
#(
    parameter int SETS    = 8,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 20,
    parameter int FLAG_W  = 8,
    parameter int VLD_POS = 3,
    localparam int NW     = (WAYS > 4) ? 4 : WAYS,
    localparam int NENT   = SETS * WAYS,
    localparam int IDX_W  = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             silent,
    output logic             done,
    output logic [IDX_W-1:0] tlb_idx,
    output logic             tlb_rd,
    input  logic [TAG_W-1:0] tlb_rdata,
    output logic             tlb_erase,
    output logic             rpt_valid,
    output logic [SET_W-1:0] rpt_set,
    output logic [WAY_W-1:0] rpt_way_lo,
    output logic [WAY_W-1:0] rpt_way_hi,
    output logic [TAG_W-1:0] rpt_tag
);

    scrub_state_t          state_q, state_d;
    logic [SET_W-1:0]      set_q;
    logic [WAY_W-1:0]      way_q;
    logic [NW-1:0][TAG_W-1:0] tags;
    logic                  any_valid;
    logic [WAY_W-1:0]      outer, inner;
    logic                  outer_last, inner_last;
    logic                  cmp_zero, cmp_hit;
    logic                  pair_init, step_outer, step_inner;
    logic                  cap, clr_any;
    logic [IDX_W-1:0]      set_base;

    scrub_tag_bank #(
        .NW(NW), .TAG_W(TAG_W), .FLAG_W(FLAG_W), .VLD_POS(VLD_POS), .WAY_W(WAY_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_any   (clr_any),
        .cap       (cap),
        .cap_way   (way_q),
        .cap_data  (tlb_rdata),
        .kill      (cmp_hit),
        .kill_way  (outer),
        .tags      (tags),
        .any_valid (any_valid)
    );

    scrub_pair_seq #(.NW(NW), .WAY_W(WAY_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (pair_init),
        .step_outer (step_outer),
        .step_inner (step_inner),
        .outer      (outer),
        .inner      (inner),
        .outer_last (outer_last),
        .inner_last (inner_last)
    );

    // Compare the current pair; a zero outer page never matches.
    always_comb begin
        cmp_zero = (state_q == S_CMP) && (tags[outer] == '0);
        cmp_hit  = (state_q == S_CMP) && !cmp_zero && (tags[outer] == tags[inner]);
    end

    // Form the linear index: read position, or the outer way when erasing.
    always_comb begin
        set_base = IDX_W'(set_q) * IDX_W'(WAYS);
        tlb_idx  = cmp_hit ? (set_base + IDX_W'(outer)) : (set_base + IDX_W'(way_q));
    end

    // Next-state and per-cycle control strobes of the walk.
    always_comb begin
        state_d    = state_q;
        pair_init  = 1'b0;
        step_outer = 1'b0;
        step_inner = 1'b0;
        cap        = 1'b0;
        clr_any    = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d = S_RD;
                clr_any = 1'b1;
            end
            S_RD:   state_d = S_WT;
            S_WT: begin
                cap     = 1'b1;
                state_d = (way_q == WAY_W'(NW - 1)) ? S_CHK : S_RD;
            end
            S_CHK: begin
                pair_init = 1'b1;
                state_d   = any_valid ? S_CMP : S_NX;
            end
            S_CMP: begin
                if (cmp_zero || cmp_hit || inner_last) begin
                    if (outer_last) state_d = S_NX;
                    else            step_outer = 1'b1;
                end else begin
                    step_inner = 1'b1;
                end
            end
            S_NX: begin
                clr_any = 1'b1;
                state_d = (set_q == SET_W'(SETS - 1)) ? S_DN : S_RD;
            end
            S_DN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State, set and way registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            set_q   <= '0;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                set_q <= '0;
                way_q <= '0;
            end else if (state_q == S_WT && way_q != WAY_W'(NW - 1)) begin
                way_q <= way_q + WAY_W'(1);
            end else if (state_q == S_NX) begin
                set_q <= set_q + SET_W'(1);
                way_q <= '0;
            end
        end
    end

    // Drive storage strobes, the report channel and the done pulse.
    always_comb begin
        tlb_rd     = (state_q == S_RD);
        tlb_erase  = cmp_hit;
        rpt_valid  = cmp_hit && !silent;
        rpt_set    = set_q;
        rpt_way_lo = outer;
        rpt_way_hi = inner;
        rpt_tag    = tags[outer];
        done       = (state_q == S_DN);
    end

endmodule

// File: rtl/scrub_chk.sv
// Protocol checker for tlb_dup_scrubber, attached by bind. Observes the
// top-level ports only.
module scrub_chk #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int IDX_W = 5,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             silent,
    input logic             done,
    input logic [IDX_W-1:0] tlb_idx,
    input logic             tlb_rd,
    input logic             tlb_erase,
    input logic             rpt_valid,
    input logic [WAY_W-1:0] rpt_way_lo,
    input logic [WAY_W-1:0] rpt_way_hi
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_rd |=> !tlb_rd);

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_rd || tlb_erase) |-> (int'(tlb_idx) < SETS * WAYS));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_erase |-> !tlb_rd);

    // R7
    rpt_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (tlb_erase && rpt_way_lo < rpt_way_hi));

    // R8
    silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_erase && silent) |-> !rpt_valid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !tlb_rd && !tlb_erase && !rpt_valid));

endmodule

bind tlb_dup_scrubber scrub_chk #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
) u_chk (.*);

// File: tb/tb_tlb_dup_scrubber.sv
// Self-checking bench: models the tag storage, runs directed and seeded
// random passes and compares against a reference walk.
module tb_tlb_dup_scrubber;

    localparam int SETS = 8, WAYS = 4, TAG_W = 20, FLAG_W = 8, VLD_POS = 3;
    localparam int NW = 4, NENT = SETS * WAYS, IDX_W = 5, SET_W = 3, WAY_W = 2;
    localparam int PW = TAG_W - FLAG_W;
    localparam logic [TAG_W-1:0] PMASK = {{PW{1'b1}}, {FLAG_W{1'b0}}};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, silent = 1'b0;
    logic done, tlb_rd, tlb_erase, rpt_valid;
    logic [IDX_W-1:0] tlb_idx;
    logic [TAG_W-1:0] tlb_rdata, rpt_tag;
    logic [SET_W-1:0] rpt_set;
    logic [WAY_W-1:0] rpt_way_lo, rpt_way_hi;

    always #5 clk = ~clk;

    tlb_dup_scrubber #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .FLAG_W(FLAG_W),
                       .VLD_POS(VLD_POS)) dut (.*);

    logic [TAG_W-1:0] mem [NENT];
    logic [TAG_W-1:0] emem [NENT];
    int e_set[64], e_lo[64], e_hi[64]; logic [TAG_W-1:0] e_tag[64]; int e_n;
    int g_set[64], g_lo[64], g_hi[64]; logic [TAG_W-1:0] g_tag[64]; int g_n;
    int rd_log[128]; int rd_n; int done_cnt;
    int checks = 0, fails = 0, cyc = 0;

    // Storage model: one-cycle read latency, erase writes zero.
    always @(posedge clk) begin
        if (tlb_rd) tlb_rdata <= mem[tlb_idx];
        if (tlb_erase) mem[tlb_idx] <= '0;
    end

    // Observe reads, reports and done away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tlb_rd) begin
                if (rd_n < 128) rd_log[rd_n] = int'(tlb_idx);
                rd_n++;
            end
            if (rpt_valid) begin
                if (g_n < 64) begin
                    g_set[g_n] = int'(rpt_set); g_lo[g_n] = int'(rpt_way_lo);
                    g_hi[g_n] = int'(rpt_way_hi); g_tag[g_n] = rpt_tag;
                end
                g_n++;
            end
            if (done) done_cnt++;
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 100000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] mk(input int page, input int flags, input bit v);
        logic [TAG_W-1:0] t;
        t = {page[PW-1:0], flags[FLAG_W-1:0]};
        t[VLD_POS] = v;
        return t;
    endfunction

    // Reference walk of the requirements over the current storage image.
    task automatic ref_walk(input bit sil);
        e_n = 0;
        for (int k = 0; k < NENT; k++) emem[k] = mem[k];
        for (int s = 0; s < SETS; s++) begin
            logic [TAG_W-1:0] tg [NW];
            bit anyv = 0;
            for (int w = 0; w < NW; w++) begin
                anyv |= mem[s*WAYS+w][VLD_POS];
                tg[w] = mem[s*WAYS+w] & PMASK;
            end
            if (anyv) begin
                for (int o = 0; o < NW - 1; o++) begin
                    bit hit = 0;
                    if (tg[o] != '0) begin
                        for (int i = o + 1; i < NW; i++) begin
                            if (!hit && tg[o] == tg[i]) begin
                                hit = 1;
                                if (!sil) begin
                                    e_set[e_n] = s; e_lo[e_n] = o; e_hi[e_n] = i;
                                    e_tag[e_n] = tg[o]; e_n++;
                                end
                                emem[s*WAYS+o] = '0;
                                tg[o] = '0;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_pass(input string name, input bit sil, input bit restart);
        int mism = 0, first = -1;
        ref_walk(sil);
        rd_n = 0; g_n = 0; done_cnt = 0;
        @(negedge clk); silent = sil; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (restart ? 200 : 4) @(negedge clk);
        // R9: exactly one done pulse per pass
        chk(done_cnt == 1, "R9", {name, " done count"}, done_cnt, 1);
        // R2: read count and ascending index order
        chk(rd_n == NENT, "R2", {name, " read count"}, rd_n, NENT);
        for (int k = 0; k < NENT && k < rd_n; k++)
            if (rd_log[k] != k && first < 0) first = k;
        chk(first < 0, "R2", {name, " read order"}, first < 0 ? 0 : rd_log[first], first);
        // R7/R8: report count and contents
        chk(g_n == e_n, sil ? "R8" : "R7", {name, " report count"}, g_n, e_n);
        for (int k = 0; k < e_n && k < g_n; k++) begin
            chk(g_set[k] == e_set[k] && g_lo[k] == e_lo[k] && g_hi[k] == e_hi[k] &&
                g_tag[k] == e_tag[k], "R7", {name, " report fields"},
                {g_set[k][7:0], g_lo[k][3:0], g_hi[k][3:0], g_tag[k]},
                {e_set[k][7:0], e_lo[k][3:0], e_hi[k][3:0], e_tag[k]});
        end
        // R6: final storage contents (erased lower ways only)
        first = -1;
        for (int k = 0; k < NENT; k++) if (mem[k] != emem[k]) begin mism++; if (first < 0) first = k; end
        chk(mism == 0, "R6", {name, " storage image"},
            first < 0 ? 0 : mem[first], first < 0 ? 0 : emem[first]);
    endtask

    task automatic fill_random();
        for (int k = 0; k < NENT; k++) begin
            int unsigned r = $urandom;
            mem[k] = mk(int'(r % 4), int'((r >> 4) & 8'hff), ((r >> 12) % 4) != 0);
        end
    endtask

    task automatic fill_directed();
        for (int k = 0; k < NENT; k++) mem[k] = '0;
        // R4: equal pages but nothing present in set 0
        mem[0] = mk(5, 8'h11, 0); mem[1] = mk(5, 8'h22, 0);
        // R3/R6: all four ways equal page, differing flags, set 1
        mem[4] = mk(7, 8'h01, 1); mem[5] = mk(7, 8'h80, 1);
        mem[6] = mk(7, 8'h43, 1); mem[7] = mk(7, 8'h10, 1);
        // R5: zero page on outer ways is skipped, set 2
        mem[8] = mk(0, 8'h05, 1); mem[9] = mk(0, 8'h0c, 1);
        // R5: inner way matches with its present flag clear, set 3
        mem[13] = mk(9, 8'h00, 1); mem[15] = mk(9, 8'h00, 0);
        // R2: last set gets scanned, set 7
        mem[30] = mk(3, 8'h00, 1); mem[31] = mk(3, 8'h00, 1);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: quiet outputs while reset is held
        chk(!done && !tlb_rd && !tlb_erase && !rpt_valid, "R1", "outputs in reset",
            {done, tlb_rd, tlb_erase, rpt_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        fill_directed();
        // R3 R4 R5 R6: directed corner sets
        run_pass("directed", 1'b0, 1'b0);
        chk(mem[0] == mk(5, 8'h11, 0) && mem[1] == mk(5, 8'h22, 0), "R4",
            "non-present set untouched", mem[1], mk(5, 8'h22, 0));
        chk(mem[4] == 0 && mem[5] == 0 && mem[6] == 0 && mem[7] == mk(7, 8'h10, 1),
            "R6", "all-equal set keeps last way", mem[7], mk(7, 8'h10, 1));
        chk(mem[8] == mk(0, 8'h05, 1) && mem[9] == mk(0, 8'h0c, 1), "R5",
            "zero page skipped", mem[8], mk(0, 8'h05, 1));
        chk(mem[13] == 0 && mem[15] == mk(9, 8'h00, 0), "R5",
            "inner without present flag matches", mem[13], 0);
        chk(e_n == 5, "R3", "flag-differing pages counted as duplicates", e_n, 5);

        fill_directed();
        // R8: silenced pass, same erasures
        run_pass("silent", 1'b1, 1'b0);

        fill_random();
        // R9: start during a pass is ignored
        run_pass("restart", 1'b0, 1'b1);

        for (int n = 0; n < 6; n++) begin
            fill_random();
            // R5 R6 R7: random pages from a small pool
            run_pass("random", 1'b0, 1'b0);
        end

        fill_random();
        // R6: second pass over scrubbed image erases nothing
        run_pass("prep", 1'b0, 1'b0);
        run_pass("rescan", 1'b0, 1'b0);
        chk(g_n == 0, "R6", "rescan reports", g_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule